// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from power-up to a usable state without any software involvement. After a synchronous reset it sends a no-operation command and then waits out the long power-up settle time. It then sends one precharge, a configurable number of auto-refresh commands (eight by default) and a single mode-register-set command. Each command after the settle wait is separated from the next by a short minimum gap. Both delays are given in nanoseconds and turned into clock cycles at elaboration time, rounding up.

The payload of the mode-register-set command is worked out from the CAS latency in the timing configuration word and from a bus-width select. A nonzero override value, when supplied, replaces the computed payload. While the sequence runs, the refresh-enable field of the timing word is forced to zero on the timing output. Once the sequence completes, the block raises a done flag, passes the timing word through unchanged, and enables the periodic refresh request.

Top module: `sdram_boot_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge), applied at any point, leaves `cmd_valid_o` at 0, `cmd_o` at 0 and `done_o` at 0 after that edge, and restarts the sequence from the beginning.
- R2: On the first clock edge that samples `rst` low, the block issues the no-operation command: `cmd_valid_o` is 1 and `cmd_o` is 0 for one cycle.
- R3: The precharge strobe comes exactly WAIT_CYC cycles after the no-operation strobe. WAIT_CYC = ceil(POWERUP_NS * CLK_KHZ / 1e6), with a minimum of 1.
- R4: After the settle wait the strobes occur in this order: one precharge (code 2'b01), REFRESH_COUNT auto-refresh commands (code 2'b10), then one mode-register-set (code 2'b11). The command code is in `cmd_o[1:0]`, and no-operation is 2'b00.
- R5: Consecutive post-wait strobes are exactly GAP_CYC cycles apart. GAP_CYC = ceil(GAP_NS * CLK_KHZ / 1e6), with a minimum of 1.
- R6: `cmd_valid_o` is high for single cycles only, and `cmd_o` is all zero on every cycle without a strobe.
- R7: The computed mode payload is 0x40 when `cfg_timing[2:0]` equals 2 and 0x60 for any other value. When `cfg_bus16` is 1 the payload is halved (0x20 or 0x30).
- R8: A nonzero `cfg_mode_override` is used as the mode payload unchanged, in place of the computed value.
- R9: The mode-register-set word is the payload in `cmd_o[9:2]` ORed with code 2'b11. Precharge and refresh words have `cmd_o[9:2]` equal to 0.
- R10: Until `done_o` rises, `timing_o` equals `cfg_timing` with bits [7:6] (the refresh-enable field) cleared. From then on it equals `cfg_timing`.
- R11: `done_o` rises GAP_CYC cycles after the mode-register-set strobe. It stays high until reset, and no further strobes are issued.
- R12: `refresh_en_o` is 1 exactly when `done_o` is 1 and `cfg_timing[7:6]` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_timing | input | 32 | Timing configuration word; [2:0] is the CAS latency, [7:6] is the refresh-enable field |
| cfg_bus16 | input | 1 | Bus-width select, 1 = 16-bit data bus |
| cfg_mode_override | input | 8 | Explicit mode payload; 0 selects the computed payload |
| cmd_o | output | 10 | Command word: code in [1:0], mode payload in [9:2] |
| cmd_valid_o | output | 1 | One-cycle strobe marking an issued command |
| timing_o | output | 32 | Timing word with the refresh field held at zero until done |
| done_o | output | 1 | Initialization complete |
| refresh_en_o | output | 1 | Periodic refresh request enable |

## Verification
Every output is registered, so a strobe that is due at cycle k after the first edge with reset low appears after edge k+1 of that count. The no-operation strobe is at k=0, precharge at k=WAIT_CYC, refresh j at WAIT_CYC+j*GAP_CYC, mode-set at WAIT_CYC+(REFRESH_COUNT+1)*GAP_CYC, and done from WAIT_CYC+(REFRESH_COUNT+2)*GAP_CYC onward. The bench builds a queue of these due cycles from the rounding formulas and counts edges since reset. It samples every output on the falling edge and compares it with the queue head, so an early or late strobe by even one cycle is reported. `timing_o` and `refresh_en_o` follow `done_o` in the same cycle, and the bench checks them on every cycle against the expected done state.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    // Two-bit command codes carried in the low bits of the command word
    typedef enum logic [1:0] {
        CMD_NOP        = 2'b00,
        CMD_PRECHARGE  = 2'b01,
        CMD_REFRESH    = 2'b10,
        CMD_MODE_SET   = 2'b11
    } sdram_cmd_e;

    typedef enum logic [1:0] {
        ST_KICK   = 2'b00,  // issue the opening no-op
        ST_SETTLE = 2'b01,  // long power-up wait
        ST_SPACE  = 2'b10,  // short gap between sequence commands
        ST_READY  = 2'b11   // sequence complete
    } seq_state_e;

    // Convert a time in ns to a cycle count at clk_khz, rounding up, minimum 1
    function automatic int ns_to_cycles(input int ns, input int clk_khz);
        longint prod;
        longint cyc;
        prod = longint'(ns) * longint'(clk_khz);
        cyc  = (prod + 64'd999999) / 64'd1000000;
        return (cyc < 1) ? 1 : int'(cyc);
    endfunction

endpackage

// File: rtl/sdram_boot_mode.sv
module sdram_boot_mode #(
    parameter int                MODE_W    = 8,
    parameter int                CL_W      = 3,
    parameter logic [MODE_W-1:0] CL2_BASE  = MODE_W'(8'h40),
    parameter logic [MODE_W-1:0] CL3_BASE  = MODE_W'(8'h60)
) (
    input  logic [CL_W-1:0]   cas_latency,
    input  logic              bus16,
    input  logic [MODE_W-1:0] override,
    output logic [MODE_W-1:0] mode_data
);

    logic [MODE_W-1:0] base;
    logic [MODE_W-1:0] sized;

    always_comb begin
        base  = (cas_latency == CL_W'(2)) ? CL2_BASE : CL3_BASE;
        // a half-width bus halves the payload
        sized = bus16 ? (base >> 1) : base;
        mode_data = (override != '0) ? override : sized;
    end

endmodule

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int CLK_KHZ       = 200000,
    parameter int POWERUP_NS    = 200000,
    parameter int GAP_NS        = 80,
    parameter int REFRESH_COUNT = 8,
    parameter int CFG_W         = 32,
    parameter int MODE_W        = 8,
    parameter int CL_W          = 3,
    parameter int REF_LSB       = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CFG_W-1:0]    cfg_timing,
    input  logic                cfg_bus16,
    input  logic [MODE_W-1:0]   cfg_mode_override,
    output logic [MODE_W+1:0]   cmd_o,
    output logic                cmd_valid_o,
    output logic [CFG_W-1:0]    timing_o,
    output logic                done_o,
    output logic                refresh_en_o
);

    localparam int WAIT_CYC  = ns_to_cycles(POWERUP_NS, CLK_KHZ);
    localparam int GAP_CYC   = ns_to_cycles(GAP_NS, CLK_KHZ);
    localparam int LONGEST   = (WAIT_CYC > GAP_CYC) ? WAIT_CYC : GAP_CYC;
    localparam int MIN_SPACE = (WAIT_CYC < GAP_CYC) ? WAIT_CYC : GAP_CYC;
    localparam int CNT_W     = $clog2(LONGEST + 1);
    localparam int STEPS     = REFRESH_COUNT + 2;   // precharge + refreshes + mode set
    localparam int IDX_W     = $clog2(STEPS + 1);
    localparam int CMD_W     = MODE_W + 2;
    localparam logic [CFG_W-1:0] REF_MASK = CFG_W'(2'b11) << REF_LSB;

    typedef struct packed {
        seq_state_e        state;
        logic [IDX_W-1:0]  idx;
        logic [CMD_W-1:0]  cmd;
        logic              valid;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [MODE_W-1:0] mode_data;
    logic [CMD_W-1:0]  step_word;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;

    sdram_boot_mode #(
        .MODE_W (MODE_W),
        .CL_W   (CL_W)
    ) u_mode (
        .cas_latency (cfg_timing[CL_W-1:0]),
        .bus16       (cfg_bus16),
        .override    (cfg_mode_override),
        .mode_data   (mode_data)
    );

    sdram_boot_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // Command word for the post-wait step selected by the index
    always_comb begin
        if (ctl_q.idx == '0) begin
            step_word = {MODE_W'(0), CMD_PRECHARGE};
        end else if (ctl_q.idx == IDX_W'(STEPS - 1)) begin
            step_word = {mode_data, CMD_MODE_SET};
        end else begin
            step_word = {MODE_W'(0), CMD_REFRESH};
        end
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.cmd   = '0;
        ctl_d.valid = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        case (ctl_q.state)
            ST_KICK: begin
                ctl_d.cmd   = {MODE_W'(0), CMD_NOP};
                ctl_d.valid = 1'b1;
                ctl_d.idx   = '0;
                ctl_d.state = ST_SETTLE;
                tmr_load    = 1'b1;
                tmr_val     = CNT_W'(WAIT_CYC - 1);
            end
            ST_SETTLE, ST_SPACE: begin
                if (tmr_expired) begin
                    if (ctl_q.idx == IDX_W'(STEPS)) begin
                        ctl_d.state = ST_READY;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.cmd   = step_word;
                        ctl_d.valid = 1'b1;
                        ctl_d.idx   = ctl_q.idx + IDX_W'(1);
                        ctl_d.state = ST_SPACE;
                        tmr_load    = 1'b1;
                        tmr_val     = CNT_W'(GAP_CYC - 1);
                    end
                end
            end
            default: begin
                ctl_d.done = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{state: ST_KICK, idx: '0, cmd: '0, valid: 1'b0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmd_o        = ctl_q.cmd;
    assign cmd_valid_o  = ctl_q.valid;
    assign done_o       = ctl_q.done;
    assign timing_o     = ctl_q.done ? cfg_timing : (cfg_timing & ~REF_MASK);
    assign refresh_en_o = ctl_q.done && (cfg_timing[REF_LSB +: 2] != 2'b00);

endmodule

// File: rtl/sdram_boot_seq_chk.sv
module sdram_boot_seq_chk #(
    parameter int CMD_W     = 10,
    parameter int MIN_SPACE = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [CMD_W-1:0] cmd_o,
    input logic             cmd_valid_o,
    input logic [1:0]       ref_field,
    input logic             done_o,
    input logic             refresh_en_o
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!done_o && !cmd_valid_o && cmd_o == '0));

    // R2
    kick_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && $past(rst)) |=> (cmd_valid_o && cmd_o == '0));

    // R6
    idle_word_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid_o |-> (cmd_o == '0));

    // R6
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        (MIN_SPACE > 1 && cmd_valid_o) |=> !cmd_valid_o);

    // R10
    refresh_masked_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> (ref_field == 2'b00));

    // R11
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o);

    // R11
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !cmd_valid_o);

    // R12
    refresh_gate_chk: assert property (@(posedge clk) disable iff (rst)
        refresh_en_o |-> done_o);

endmodule

bind sdram_boot_seq sdram_boot_seq_chk #(
    .CMD_W     (CMD_W),
    .MIN_SPACE (MIN_SPACE)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_o        (cmd_o),
    .cmd_valid_o  (cmd_valid_o),
    .ref_field    (timing_o[REF_LSB +: 2]),
    .done_o       (done_o),
    .refresh_en_o (refresh_en_o)
);

// File: tb/sdram_boot_seq_test.sv
`timescale 1ns/1ps
module sdram_boot_seq_test;

    localparam int KHZ     = 200000;
    localparam int PWR_NS  = 1999;   // rounds up to 400 cycles
    localparam int GAP_NS  = 77;     // rounds up to 16 cycles
    localparam int NREF    = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_timing = '0;
    logic        cfg_bus16 = 1'b0;
    logic [7:0]  cfg_mode_override = '0;
    logic [9:0]  cmd_o;
    logic        cmd_valid_o;
    logic [31:0] timing_o;
    logic        done_o;
    logic        refresh_en_o;

    sdram_boot_seq #(
        .CLK_KHZ       (KHZ),
        .POWERUP_NS    (PWR_NS),
        .GAP_NS        (GAP_NS),
        .REFRESH_COUNT (NREF)
    ) uut (
        .clk               (clk),
        .rst               (rst),
        .cfg_timing        (cfg_timing),
        .cfg_bus16         (cfg_bus16),
        .cfg_mode_override (cfg_mode_override),
        .cmd_o             (cmd_o),
        .cmd_valid_o       (cmd_valid_o),
        .timing_o          (timing_o),
        .done_o            (done_o),
        .refresh_en_o      (refresh_en_o)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int n = 0;          // edges since reset release
    int wd = 0;
    bit armed = 1'b0;
    int W;
    int G;
    int done_at;

    int          q_at[$];
    logic [9:0]  q_word[$];
    string       q_tag[$];
    logic [1:0]  obs[$];
    logic [7:0]  seen_mode;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
        wd <= wd + 1;
        if (wd > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Reference model: compare every output on every falling edge
    always @(negedge clk) begin
        if (armed) begin
            if (n == 0) begin
                chk(cmd_valid_o == 1'b0 && cmd_o == '0, "R1 strobe in reset", {cmd_valid_o, cmd_o}, 0);
                chk(done_o == 1'b0, "R1 done in reset", done_o, 0);
                chk(timing_o == (cfg_timing & ~32'hC0), "R10 timing in reset", timing_o, cfg_timing & ~32'hC0);
            end else begin
                automatic int k = n - 1;
                automatic bit ev = (q_at.size() > 0) && (q_at[0] == k);
                automatic logic [9:0] ew = ev ? q_word[0] : 10'd0;
                automatic string tg = ev ? q_tag[0] : "R6";
                automatic bit ed = (k >= done_at);
                automatic logic [31:0] et = ed ? cfg_timing : (cfg_timing & ~32'hC0);
                automatic bit er = ed && (cfg_timing[7:6] != 2'b00);
                if (ev) begin
                    void'(q_at.pop_front());
                    void'(q_word.pop_front());
                    void'(q_tag.pop_front());
                end
                chk(cmd_valid_o == ev, tg, cmd_valid_o, ev);
                chk(cmd_o == ew, tg, cmd_o, ew);
                chk(done_o == ed, "R11 done", done_o, ed);
                chk(timing_o == et, "R10 timing word", timing_o, et);
                chk(refresh_en_o == er, "R12 refresh enable", refresh_en_o, er);
                if (cmd_valid_o) begin
                    obs.push_back(cmd_o[1:0]);
                    if (cmd_o[1:0] == 2'b11) seen_mode = cmd_o[9:2];
                end
            end
        end
    end

    task automatic run_case(input logic [31:0] t, input logic b16, input logic [7:0] ovr, input int stop_after);
        automatic logic [7:0] base = (t[2:0] == 3'd2) ? 8'h40 : 8'h60;
        automatic logic [7:0] em = (ovr != 0) ? ovr : (b16 ? (base >> 1) : base);
        cfg_timing = t;
        cfg_bus16 = b16;
        cfg_mode_override = ovr;
        q_at.delete(); q_word.delete(); q_tag.delete(); obs.delete();
        seen_mode = 8'h00;
        q_at.push_back(0);     q_word.push_back(10'd0);         q_tag.push_back("R2 opening no-op");
        q_at.push_back(W);     q_word.push_back(10'b01);        q_tag.push_back("R3 precharge after wait");
        for (int j = 1; j <= NREF; j++) begin
            q_at.push_back(W + j * G); q_word.push_back(10'b10); q_tag.push_back("R5 refresh spacing");
        end
        q_at.push_back(W + (NREF + 1) * G); q_word.push_back({em, 2'b11}); q_tag.push_back("R9 mode-set word");
        done_at = W + (NREF + 2) * G;
        rst = 1'b0;
        if (stop_after > 0) begin
            repeat (stop_after) @(negedge clk);
        end else begin
            repeat (done_at + 20) @(negedge clk);
            // R4: order of strobes
            chk(obs.size() == NREF + 3, "R4 strobe count", obs.size(), NREF + 3);
            if (obs.size() == NREF + 3) begin
                chk(obs[0] == 2'b00 && obs[1] == 2'b01, "R4 leading codes", {obs[0], obs[1]}, 4'b0001);
                for (int j = 2; j <= NREF + 1; j++)
                    chk(obs[j] == 2'b10, "R4 refresh code", obs[j], 2'b10);
                chk(obs[NREF + 2] == 2'b11, "R4 final mode-set code", obs[NREF + 2], 2'b11);
            end
            if (ovr != 0) chk(seen_mode == em, "R8 override payload", seen_mode, em);
            else          chk(seen_mode == em, "R7 computed payload", seen_mode, em);
        end
        rst = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        W = int'((longint'(PWR_NS) * KHZ + 999999) / 1000000);
        G = int'((longint'(GAP_NS) * KHZ + 999999) / 1000000);
        done_at = 1 << 30;
        repeat (2) @(negedge clk);
        armed = 1'b1;
        @(negedge clk);
        run_case(32'h0000_00C2, 1'b0, 8'h00, 0);   // CL2, 32-bit -> 0x40
        run_case(32'h0000_0083, 1'b1, 8'h00, 0);   // CL3, 16-bit -> 0x30
        run_case(32'h0000_0042, 1'b1, 8'h00, 0);   // CL2, 16-bit -> 0x20
        run_case(32'h0000_0005, 1'b0, 8'h00, 0);   // other CL, field 00 -> 0x60, no refresh
        run_case(32'h0000_00C3, 1'b1, 8'h5A, 0);   // R8 override
        run_case(32'h0000_00C2, 1'b0, 8'h00, W + 3 * G + 4);  // R1 reset mid-sequence
        run_case(32'h0000_00C2, 1'b0, 8'h00, 0);   // R1 full restart after abort
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule